// File: doc/BRIEF.md
# Pre-Encoded Signed-Digit Multiplier

This block multiplies a two's complement operand by a coefficient that was recoded offline into a compact radix-4 signed-digit word. Every digit below the top one takes a value in {-2, -1, 0, +1} and is held in two bits. The top digit is a full radix-4 Booth digit in {-2 .. +2} and is held in three bits. The coefficient word is therefore one bit wider than the operand. Because the recoding is already done, the block needs no on-line Booth encoder. A few gates per digit produce the select signals. One partial product is formed per digit. The negation carries are gathered into a single correction word, and a carry-save chain reduces all of them. A parallel-prefix adder then merges the result into the full-width product.

The caller holds the coefficients in a memory of its own. Each cycle it presents one operand and one encoded coefficient with a valid strobe. The product appears in a register one cycle later, together with a matching valid flag. When no new valid input arrives, the product register keeps its old value.

Top module: `nr4_mul`

## Requirements
- R1: While `rst_n` is low, `valid_out` is 0 and `product` is 0.
- R2: `valid_out` equals the value `valid_in` had at the previous rising clock edge. A valid input therefore yields its product exactly one cycle later.
- R3: For each lower digit j (0 <= j < WIDTH/2-1), bit 2j of `coef` is a positive unit bit p and bit 2j+1 is a negative-two bit m. The digit value is p - 2m, so the codes {m,p} = 00, 01, 10 and 11 mean 0, +1, -2 and -1. Each digit carries weight 4^j.
- R4: The top digit uses bit WIDTH-2 (magnitude one), bit WIDTH-1 (magnitude two) and bit WIDTH (sign, 1 = negative). It carries weight 4^(WIDTH/2-1). The codes 000, 001, 010, 101 and 110 (sign, two, one) mean 0, +1, +2, -1 and -2.
- R5: `product` is the 2*WIDTH-bit two's complement value of `a` times the coefficient value that R3 and R4 define. This holds for every operand value, including the most negative one.
- R6: While `valid_in` is 0, `product` keeps its value.
- R7: A top digit whose sign bit is set while both magnitude bits are 0 contributes nothing to the product.
- R8: The coefficient range ends -2^(WIDTH-1) and 2^(WIDTH-1)-1 give correct products when paired with the operand range ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operand and coefficient are valid this cycle |
| a | input | WIDTH | Two's complement operand |
| coef | input | WIDTH+1 | Pre-encoded signed-digit coefficient |
| valid_out | output | 1 | Product register holds a new result |
| product | output | 2*WIDTH | Registered two's complement product |

## Verification
The risky case is a cycle in which the negation carries of the lower digits and the sign of the top Booth digit all land in the correction word together, while the inverted, sign-extended partial products stretch the carry chain across the full width. Two coefficients provoke this: one encoded with many negative digits, and the most negative coefficient, whose top digit alone is -2. Each is paired with the most negative and most positive operands. An exhaustive sweep of all operand and coefficient pairs through the encoder follows. The scoreboard compares every product against the plain integer product of the operand and the coefficient value. The hold of the product register during idle cycles is checked at the port.

// File: rtl/nr4_mul.sv
module nr4_mul #(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_in,
  input  logic [WIDTH-1:0]     a,
  input  logic [WIDTH:0]       coef,
  output logic                 valid_out,
  output logic [2*WIDTH-1:0]   product
);
  localparam int K  = WIDTH / 2;
  localparam int PW = 2 * WIDTH;
  localparam int LV = $clog2(PW);

  logic [PW-1:0] pp [K];
  logic [K-1:0]  cin;
  logic [PW-1:0] cor;

  for (genvar j = 0; j < K; j++) begin : g_dig
    logic sgn, one, two;
    if (j < K - 1) begin : g_low
      logic one_p, one_n, two_n;
      assign one_p = coef[2*j] & ~coef[2*j+1];
      assign one_n = coef[2*j] &  coef[2*j+1];
      assign two_n = coef[2*j+1] & ~coef[2*j];
      assign one = one_p | one_n;
      assign two = two_n;
      assign sgn = one_n | two_n;
    end else begin : g_top
      assign one = coef[WIDTH-2];
      assign two = coef[WIDTH-1];
      assign sgn = coef[WIDTH];
    end
    logic [WIDTH:0] mag;
    logic [PW-1:0]  ext;
    assign mag = two ? {a, 1'b0} : (one ? {a[WIDTH-1], a} : '0);
    assign ext = {{(PW-WIDTH-1){mag[WIDTH]}}, mag};
    assign pp[j]  = (sgn ? ~ext : ext) << (2*j);
    assign cin[j] = sgn;
  end

  always_comb begin
    cor = '0;
    for (int j = 0; j < K; j++) cor[2*j] = cin[j];
  end

  logic [PW-1:0] cs_s [K+1];
  logic [PW-1:0] cs_c [K+1];
  assign cs_s[0] = cor;
  assign cs_c[0] = '0;
  for (genvar j = 0; j < K; j++) begin : g_csa
    assign cs_s[j+1] = cs_s[j] ^ cs_c[j] ^ pp[j];
    assign cs_c[j+1] = ((cs_s[j] & cs_c[j]) | (cs_s[j] & pp[j]) | (cs_c[j] & pp[j])) << 1;
  end

  logic [PW-1:0] gk [LV+1];
  logic [PW-1:0] pk [LV];
  assign gk[0] = cs_s[K] & cs_c[K];
  assign pk[0] = cs_s[K] ^ cs_c[K];
  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < PW; i++) begin : g_bit
      if (i >= D) begin : g_mrg
        assign gk[l+1][i] = gk[l][i] | (pk[l][i] & gk[l][i-D]);
        if (l + 1 < LV) begin : g_p
          assign pk[l+1][i] = pk[l][i] & pk[l][i-D];
        end
      end else begin : g_pass
        assign gk[l+1][i] = gk[l][i];
        if (l + 1 < LV) begin : g_p
          assign pk[l+1][i] = pk[l][i];
        end
      end
    end
  end

  logic [PW-1:0] sum;
  assign sum = pk[0] ^ (gk[LV] << 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      product   <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) product <= sum;
    end
  end
endmodule

module nr4_mul_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               valid_in,
  input logic [WIDTH-1:0]   a,
  input logic [WIDTH:0]     coef,
  input logic               valid_out,
  input logic [2*WIDTH-1:0] product
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!valid_out && product == '0));
  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
  assert_zero_coef_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && coef == '0) |=> product == '0);
  assert_zero_operand_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && a == '0) |=> product == '0);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(product));
  assert_neg_zero_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && coef == {1'b1, {WIDTH{1'b0}}}) |=> product == '0);
endmodule

bind nr4_mul nr4_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .a(a), .coef(coef),
  .valid_out(valid_out), .product(product)
);

// File: tb/tb_nr4_mul.sv
module tb_nr4_mul;
  localparam int N = 8;
  localparam int K = N / 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           valid_in = 1'b0;
  logic [N-1:0]   a = '0;
  logic [N:0]     coef = '0;
  logic           valid_out;
  logic [2*N-1:0] product;

  int checks = 0;
  int errors = 0;
  logic [2*N-1:0] exp_q [$];
  string          tag_q [$];
  logic [2*N-1:0] last_exp;

  nr4_mul #(.WIDTH(N)) dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .a(a), .coef(coef),
    .valid_out(valid_out), .product(product)
  );

  always #4 clk = ~clk;

  function automatic logic [N:0] encode(input logic [N-1:0] b);
    logic [N:0] w;
    logic c, c1;
    int v;
    w = '0;
    c = 1'b0;
    for (int j = 0; j < K - 1; j++) begin
      w[2*j]   = b[2*j] ^ c;
      c1       = b[2*j] & c;
      w[2*j+1] = b[2*j+1] ^ c1;
      c        = b[2*j+1] | c1;
    end
    v = -2 * int'(b[N-1]) + int'(b[N-2]) + int'(c);
    w[N-2] = (v == 1) || (v == -1);
    w[N-1] = (v == 2) || (v == -2);
    w[N]   = (v < 0);
    return w;
  endfunction

  function automatic int coef_value(input logic [N:0] w);
    int v, t;
    v = 0;
    for (int j = 0; j < K - 1; j++)
      v += (int'(w[2*j]) - 2 * int'(w[2*j+1])) * (4 ** j);
    t = int'(w[N-2]) + 2 * int'(w[N-1]);
    if (w[N]) t = -t;
    return v + t * (4 ** (K - 1));
  endfunction

  function automatic logic [2*N-1:0] mulref(input logic [N-1:0] x, input int v);
    int p;
    p = int'($signed(x)) * v;
    return p[2*N-1:0];
  endfunction

  task automatic send(input logic [N-1:0] x, input logic [N:0] w,
                      input logic [2*N-1:0] e, input string tag);
    @(negedge clk);
    a = x;
    coef = w;
    valid_in = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_exp = e;
  endtask

  task automatic check(input bit ok, input string tag, input logic [2*N-1:0] act,
                       input logic [2*N-1:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && valid_out) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected valid_out", product, '0);
        end else begin
          logic [2*N-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(product == e, t, product, e);
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [N-1:0] corner [4];
    corner[0] = 8'h80; corner[1] = 8'h7f; corner[2] = 8'hff; corner[3] = 8'h05;

    repeat (3) @(negedge clk);
    check(valid_out == 1'b0 && product == '0, "R1 reset state", product, '0);
    rst_n = 1'b1;

    // R3: every lower digit position and code
    for (int j = 0; j < K - 1; j++)
      for (int code = 0; code < 4; code++)
        for (int ai = 0; ai < 4; ai++) begin
          logic [N:0] w;
          w = '0;
          w[2*j]   = code[0];
          w[2*j+1] = code[1];
          send(corner[ai], w,
               mulref(corner[ai], (code % 2 - 2 * (code / 2)) * (4 ** j)), "R3 lower digit");
        end

    // R4: top digit codes (sign, two, one)
    for (int ai = 0; ai < 4; ai++) begin
      send(corner[ai], 9'b001000000, mulref(corner[ai],  64), "R4 top +1");
      send(corner[ai], 9'b010000000, mulref(corner[ai], 128), "R4 top +2");
      send(corner[ai], 9'b101000000, mulref(corner[ai], -64), "R4 top -1");
      send(corner[ai], 9'b110000000, mulref(corner[ai], -128), "R4 top -2");
      send(corner[ai], 9'b110101111,
           mulref(corner[ai], coef_value(9'b110101111)), "R4 mixed digits");
    end

    // R7: negative sign with zero magnitude
    for (int ai = 0; ai < 4; ai++)
      send(corner[ai], 9'b100000000, '0, "R7 signed zero top digit");

    // R8: range ends of both operands
    for (int ai = 0; ai < 2; ai++) begin
      send(corner[ai], encode(8'h80), mulref(corner[ai], -128), "R8 coef min");
      send(corner[ai], encode(8'h7f), mulref(corner[ai],  127), "R8 coef max");
      send(corner[ai], encode(8'hff), mulref(corner[ai],   -1), "R8 coef minus one");
      send(corner[ai], encode(8'haa), mulref(corner[ai],  -86), "R8 many negative digits");
    end

    // R5: exhaustive sweep through the encoder
    for (int x = 0; x < 256; x++)
      for (int b = 0; b < 256; b++)
        send(x[N-1:0], encode(b[N-1:0]),
             mulref(x[N-1:0], int'($signed(b[N-1:0]))), "R5 product");

    // R6: idle with changing inputs, product held
    @(negedge clk);
    valid_in = 1'b0;
    a = 8'h33;
    coef = 9'b010000001;
    @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      a = a + 8'h11;
      check(product == last_exp, "R6 product held", product, last_exp);
      check(valid_out == 1'b0, "R2 valid_out low when idle", {15'd0, valid_out}, '0);
    end
    check(exp_q.size() == 0, "R2 every result delivered", 16'(exp_q.size()), '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule